// File: doc/BRIEF.md
# Reshapeable Single-Port Block Memory

This block is a single-port memory with a fixed store of 2048 bits. The word width is chosen at elaboration time from 16, 8, 4, 2 or 1 bit, which gives depths of 128, 256, 512, 1024 or 2048 words. The address port is as wide as that depth needs, from 7 to 11 bits, and the data ports are exactly one word wide.

Write data, address and write request are captured together in an input register stage. That stage runs on the input clock and loads only while its clock enable is high. A strobe stage turns each captured write request into one write into the store. The word at the captured address goes through an output register on a separate output clock. That register has its own clock enable. Every register clears asynchronously when the active-high reset is raised. The store itself has no reset.

Narrow words are packed into the store so that word N covers store bits N*W to N*W+W-1, where W is the word width. A read that coincides with a write to the same word returns the contents from before the write.

Top module: `cfg_spram`

## Requirements
- R1: With word width W, the memory holds 2048/W independent words at addresses 0 to 2048/W-1. Each address returns the last value written to it.
- R2: Data, address and write request are captured at a rising input-clock edge only when `in_ce` is high. A request presented while `in_ce` is low is ignored.
- R3: The output register loads at a rising output-clock edge only when `out_ce` is high. Otherwise `rd_data` keeps its value, even if the captured address changes.
- R4: Consider an address that is presented and captured at input-clock edge k, with both clocks sharing one edge. The word at that address appears on `rd_data` after edge k+1.
- R5: If a write to the addressed word takes effect at the same edge that loads the output register, `rd_data` shows the word's contents from before that write (read-before-write).
- R6: Each captured write request with `wr_en` high produces exactly one write, and that write changes only the W bits of the addressed word. Neighbouring words keep their values.
- R7: While `rst` is high, `rd_data` and all captured inputs are zero, without waiting for a clock edge. No write takes place after reset until a new request with `wr_en` high has been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_clk | input | 1 | Clock for the input registers and store writes |
| in_ce | input | 1 | Load enable for the input registers |
| out_clk | input | 1 | Clock for the output register |
| out_ce | input | 1 | Load enable for the output register |
| rst | input | 1 | Asynchronous active-high clear of all registers |
| wr_en | input | 1 | Write request |
| addr | input | log2(2048/DATA_W) | Word address |
| wr_data | input | DATA_W | Word to write |
| rd_data | output | DATA_W | Registered read word |

## Verification
The bench targets the 4-bit shape. It fills every word and then overwrites scattered words. A wrong packing offset would then corrupt neighbours or alias two addresses. It writes a word and reads it at the same edge. A design that forwarded the new value there would show the write data instead of the old word. Requests are driven while `in_ce` is low; a leaky input stage would commit them, and checking those addresses afterwards exposes this. The bench also changes the address while `out_ce` is low, so an output register that ignores its enable would change. Reset is raised between clock edges to expose a synchronous clear or a write left pending after reset.

// File: rtl/cfg_spram_pkg.sv
package cfg_spram_pkg;

    localparam int STORE_BITS = 2048;

    function automatic int words_for(input int width);
        return STORE_BITS / width;
    endfunction

    function automatic bit width_is_legal(input int width);
        return (width == 1) || (width == 2) || (width == 4) ||
               (width == 8) || (width == 16);
    endfunction

    function automatic int lane_shift(input int width);
        return $clog2(width);
    endfunction

endpackage

// File: rtl/cfg_spram_in_stage.sv
module cfg_spram_in_stage #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 7
) (
    input  logic              in_clk,
    input  logic              rst,
    input  logic              in_ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } req_t;

    req_t req_q;
    req_t req_d;

    always_comb begin
        req_d.we = wr_en;
        req_d.a  = addr;
        req_d.d  = wr_data;
    end

    always_ff @(posedge in_clk or posedge rst) begin
        if (rst)        req_q <= '0;
        else if (in_ce) req_q <= req_d;
    end

    assign we_q   = req_q.we;
    assign addr_q = req_q.a;
    assign data_q = req_q.d;

    // R2
    in_hold_chk: assert property (@(posedge in_clk) disable iff (rst)
        !in_ce |=> $stable(req_q));
endmodule

// File: rtl/cfg_spram_strobe.sv
module cfg_spram_strobe (
    input  logic in_clk,
    input  logic rst,
    input  logic in_ce,
    input  logic we_q,
    output logic wr_stb
);
    logic fresh_q;

    always_ff @(posedge in_clk or posedge rst) begin
        if (rst) fresh_q <= 1'b0;
        else     fresh_q <= in_ce;
    end

    assign wr_stb = fresh_q & we_q;
endmodule

// File: rtl/cfg_spram_store.sv
module cfg_spram_store
    import cfg_spram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 7
) (
    input  logic              in_clk,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] rd_word
);
    localparam int SHIFT  = lane_shift(DATA_W);
    localparam int BASE_W = $clog2(STORE_BITS);

    logic [STORE_BITS-1:0] bits_q;
    logic [BASE_W-1:0]     base;

    assign base = BASE_W'(addr_q) << SHIFT;

    always_ff @(posedge in_clk) begin
        if (wr_stb) bits_q[base +: DATA_W] <= data_q;
    end

    assign rd_word = bits_q[base +: DATA_W];
endmodule

// File: rtl/cfg_spram_out_stage.sv
module cfg_spram_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              out_clk,
    input  logic              rst,
    input  logic              out_ce,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge out_clk or posedge rst) begin
        if (rst)         q <= '0;
        else if (out_ce) q <= d;
    end

    // R3
    out_hold_chk: assert property (@(posedge out_clk) disable iff (rst)
        !out_ce |=> $stable(q));

    // R7
    out_clear_chk: assert property (@(posedge out_clk)
        rst |-> (q == '0));
endmodule

// File: rtl/cfg_spram.sv
module cfg_spram
    import cfg_spram_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int DEPTH  = words_for(DATA_W),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              in_clk,
    input  logic              in_ce,
    input  logic              out_clk,
    input  logic              out_ce,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    generate
        if (!width_is_legal(DATA_W)) begin : g_bad_width
            $error("cfg_spram: DATA_W must be 1, 2, 4, 8 or 16");
        end
    endgenerate

    logic              we_q;
    logic              wr_stb;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_word;

    cfg_spram_in_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_in (
        .in_clk (in_clk),
        .rst    (rst),
        .in_ce  (in_ce),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .we_q   (we_q),
        .addr_q (addr_q),
        .data_q (data_q)
    );

    cfg_spram_strobe u_stb (
        .in_clk(in_clk),
        .rst   (rst),
        .in_ce (in_ce),
        .we_q  (we_q),
        .wr_stb(wr_stb)
    );

    cfg_spram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .in_clk (in_clk),
        .wr_stb (wr_stb),
        .addr_q (addr_q),
        .data_q (data_q),
        .rd_word(rd_word)
    );

    cfg_spram_out_stage #(.DATA_W(DATA_W)) u_out (
        .out_clk(out_clk),
        .rst    (rst),
        .out_ce (out_ce),
        .d      (rd_word),
        .q      (rd_data)
    );

    // R6
    one_write_chk: assert property (@(posedge in_clk) disable iff (rst)
        wr_stb |-> $past(in_ce && wr_en));

    // R7
    no_write_in_reset_chk: assert property (@(posedge in_clk)
        rst |-> !wr_stb);
endmodule

// File: tb/cfg_spram_tb_top.sv
module cfg_spram_tb_top;
    localparam int W     = 4;
    localparam int DEPTH = 2048 / W;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_ce = 1'b0, out_ce = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;

    always #10 clk = ~clk;

    cfg_spram #(.DATA_W(W)) dut_i (
        .in_clk(clk), .in_ce(in_ce), .out_clk(clk), .out_ce(out_ce),
        .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data)
    );

    int tests = 0;
    int fails = 0;
    string phase = "R7";

    // behavioural model
    int     mem_m   [DEPTH];
    bit     known_m [DEPTH];
    bit     m_we, m_cap;
    int     m_a, m_d;
    int     m_out;
    bit     m_out_known;

    initial for (int i = 0; i < DEPTH; i++) known_m[i] = 1'b0;

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_we = 0; m_cap = 0; m_a = 0; m_d = 0;
            m_out = 0; m_out_known = 1;
        end else begin
            if (out_ce) begin
                m_out       = mem_m[m_a];
                m_out_known = known_m[m_a];
            end
            if (m_cap && m_we) begin
                mem_m[m_a]   = m_d;
                known_m[m_a] = 1;
            end
            m_cap = in_ce;
            if (in_ce) begin
                m_we = wr_en; m_a = int'(addr); m_d = int'(wr_data);
            end
        end
    end

    task automatic check_now();
        if (m_out_known) begin
            tests++;
            if (int'(rd_data) != m_out) begin
                fails++;
                $display("FAIL %s: rd_data=%0h expected %0h", phase, rd_data, m_out);
            end
        end
    endtask

    task automatic cyc(input bit we, input int a, input int d, input bit ice, input bit oce);
        @(negedge clk);
        check_now();
        wr_en = we; addr = AW'(a); wr_data = W'(d); in_ce = ice; out_ce = oce;
    endtask

    function automatic int pat(input int i);
        return (i ^ (i >> 3) ^ 5) & 4'hF;
    endfunction

    initial begin
        int cycles;
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: cycles=%0d expected <=100000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        tests++;
        if (rd_data !== '0) begin
            fails++;
            $display("FAIL R7: rd_data=%0h expected 0", rd_data);
        end
        rst = 1'b0;

        // R1: fill every word, then read back
        phase = "R1";
        for (int i = 0; i < DEPTH; i++) cyc(1, i, pat(i), 1, 1);
        for (int i = 0; i < DEPTH; i++) cyc(0, i, 0, 1, 1);

        // R6: sparse overwrites, neighbours checked
        phase = "R6";
        for (int i = 40; i < 48; i += 3) cyc(1, i, ~pat(i), 1, 1);
        for (int i = 38; i < 50; i++) cyc(0, i, 0, 1, 1);

        // R4: latency on alternating addresses
        phase = "R4";
        for (int i = 0; i < 16; i++) cyc(0, (i * 37) % DEPTH, 0, 1, 1);

        // R5: write same word on consecutive cycles, reads show old
        phase = "R5";
        for (int i = 0; i < 6; i++) cyc(1, 77, i + 9, 1, 1);
        cyc(0, 77, 0, 1, 1);
        cyc(0, 77, 0, 1, 1);

        // R2: requests while in_ce low are ignored
        phase = "R2";
        cyc(0, 3, 0, 1, 1);
        for (int i = 0; i < 5; i++) cyc(1, 100 + i, 4'hA, 0, 1);
        for (int i = 0; i < 5; i++) cyc(0, 100 + i, 0, 1, 1);
        cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 0, 1, 1);

        // R3: output holds while out_ce low
        phase = "R3";
        cyc(0, 200, 0, 1, 1);
        for (int i = 0; i < 8; i++) cyc(0, 201 + i, 0, 1, 0);
        cyc(0, 210, 0, 1, 1);
        cyc(0, 211, 0, 1, 1);

        // R7: asynchronous clear mid-run, no spurious write after
        phase = "R7";
        cyc(1, 300, 4'h3, 1, 1);
        #5 rst = 1'b1;
        #1;
        tests++;
        if (rd_data !== '0) begin
            fails++;
            $display("FAIL R7: rd_data=%0h expected 0 (async)", rd_data);
        end
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);
        cyc(0, 300, 0, 1, 1);
        cyc(0, 301, 0, 1, 1);
        cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 0, 1, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule